// File: doc/BRIEF.md
# Serial NOR Flash Program Target

This block models the target side of a serial NOR flash as it appears on four SPI pins: chip select, serial clock, data in and data out. It decodes three commands: setting the write-enable latch, programming a page, and reading the status byte. A program request runs as a self-timed cycle, and during that cycle the block reports itself busy. The cycle merges the received data into a small page-organised byte array. Its length is a parameter in system clock cycles, so a simulation can run it short while the handshake stays the same. A combinational backdoor port reads the array directly.

The SPI pins are sampled by the system clock. Serial clock edges are found by comparing each sample with the previous one. The serial link runs in mode 0: the target captures on the rising edge and drives its output after the falling edge. A frame state machine has six states:

- ST_IDLE waits for the opcode.
  - 0x06 moves to ST_WREN.
  - 0x05 moves to ST_STATUS.
  - 0x02 moves to ST_ADDR if the latch is set and the block is idle. Otherwise it moves to ST_IGNORE.
  - Any other opcode moves to ST_IGNORE.
- ST_ADDR collects three address bytes and then moves to ST_DATA.
- ST_DATA stores data bytes in a page buffer.
- ST_STATUS streams the status byte.
- ST_IGNORE swallows everything else.
- ST_WREN moves to ST_IGNORE if any further byte arrives.

Every state returns to ST_IDLE when chip select rises. At that edge a frame sitting in ST_WREN or ST_DATA may commit, provided the bit count is on a byte boundary.

Top module: `nor_prog_target`

## Requirements
- R1: After reset the status byte reads 0x00 and every array byte reads 0xFF through the backdoor port.
- R2: Opcode 0x05 returns the status byte most significant bit first, with bit 0 = BUSY and bit 1 = write-enable latch (WEL). Further clocked bytes in the same frame return a freshly sampled status byte, and the command is answered while BUSY is 1.
- R3: A frame that holds only opcode 0x06 and ends on a byte boundary sets WEL. If BUSY is 1 or chip select rises mid-byte, the frame has no effect.
- R4: A program frame has five parts in this order:
  - opcode 0x02;
  - address byte 23:16;
  - address byte 15:8;
  - address byte 7:0;
  - one or more data bytes.

  When it commits, the addressed page is updated. Address bits 7:0 give the byte offset and bits ADDR_W-1:8 give the page.
- R5: A program frame is discarded with no change to the array or WEL if chip select rises mid-byte or before any data byte is complete.
- R6: A program frame received while WEL is 0 is discarded.
- R7: A committed program sets BUSY for exactly TPP_CYCLES clock cycles, starting on the clock after the chip-select rise is sampled. WEL is cleared when the cycle ends.
- R8: A program frame received while BUSY is 1 is discarded, and the page it names keeps its contents.
- R9: Programming only clears bits: each written byte becomes old value AND received value.
- R10: Data past offset 0xFF wraps to offset 0x00 of the same page. When an offset is written twice in one frame, the later byte is used.
- R11: Unknown opcodes are ignored without changing WEL, and the data-out pin is 0 whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data into the target |
| spi_miso | output | 1 | Serial data out of the target |
| bd_addr | input | ADDR_W | Backdoor byte address |
| bd_data | output | 8 | Backdoor read data |

## Verification
The bench aims at frames that almost commit. These are a chip-select rise three bits into a byte, a frame ending right after the address, a program with the latch clear, and a second program issued while the first is still busy. A design that checked these conditions loosely would punch or corrupt page contents, or leave the latch in the wrong state.

It times status reads to fall just before and just after the programmed busy window. This catches a cycle that ends early, ends late, or forgets to clear the latch.

It writes past the end of a page, including one frame long enough to overwrite its own start. A design that carried the wrap into the next page, or merged the two writes to one offset, would leave bytes that differ from the arithmetic model.

Repeated programs to one region confirm that bits are only ever cleared.

// File: rtl/nor_prog_pkg.sv
package nor_prog_pkg;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam int         PAGE_BITS  = 8;
    localparam int         PAGE_BYTES = 1 << PAGE_BITS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREN,
        ST_ADDR,
        ST_DATA,
        ST_STATUS,
        ST_IGNORE
    } frame_st_t;
endpackage

// File: rtl/nor_spi_shifter.sv
module nor_spi_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       byte_valid,
    output logic [7:0] rx_byte,
    output logic       on_boundary,
    output logic       cs_rise
);
    logic       sck_q, cs_q;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;
    logic       sck_rise, sck_fall;

    assign sck_rise    = ~cs_n & sck & ~sck_q;
    assign sck_fall    = ~cs_n & ~sck & sck_q;
    assign cs_rise     = cs_n & ~cs_q;
    assign byte_valid  = sck_rise && (bit_cnt == 3'd7);
    assign rx_byte     = {rx_sh, mosi};
    assign on_boundary = (bit_cnt == 3'd0);
    assign miso        = ~cs_n & tx_sh[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q   <= 1'b0;
            cs_q    <= 1'b1;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_n) begin
                bit_cnt <= '0;
                tx_sh   <= '0;
            end else begin
                if (sck_rise) begin
                    rx_sh   <= {rx_sh[5:0], mosi};
                    bit_cnt <= bit_cnt + 3'd1;
                end
                if (tx_load)
                    tx_sh <= tx_byte;
                else if (sck_fall && bit_cnt != 3'd0)
                    tx_sh <= {tx_sh[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_prog_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      byte_valid,
    input  logic [7:0]                rx_byte,
    input  logic                      cs_rise,
    input  logic                      on_boundary,
    input  logic                      busy,
    input  logic                      prog_done,
    input  logic [PAGE_BITS-1:0]      rd_idx,
    output logic                      tx_load,
    output logic [7:0]                tx_byte,
    output logic                      wel,
    output logic                      commit,
    output logic [ADDR_W-PAGE_BITS-1:0] prog_page,
    output logic [7:0]                buf_byte,
    output logic                      buf_hit
);
    localparam int PGW = ADDR_W - PAGE_BITS;

    frame_st_t             state, nxt;
    logic [1:0]            addr_cnt;
    logic [15:0]           addr_hi;
    logic [PAGE_BITS-1:0]  wr_off;
    logic                  data_seen;
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pmask;
    logic                  wren_ok;
    logic                  unused_hi;

    assign unused_hi = ^addr_hi;

    always_comb begin
        nxt = state;
        if (cs_rise)
            nxt = ST_IDLE;
        else if (byte_valid) begin
            unique case (state)
                ST_IDLE: begin
                    case (rx_byte)
                        OP_WREN: nxt = ST_WREN;
                        OP_RDSR: nxt = ST_STATUS;
                        OP_PROG: nxt = (wel && !busy) ? ST_ADDR : ST_IGNORE;
                        default: nxt = ST_IGNORE;
                    endcase
                end
                ST_WREN:   nxt = ST_IGNORE;
                ST_ADDR:   nxt = (addr_cnt == 2'd2) ? ST_DATA : ST_ADDR;
                ST_DATA:   nxt = ST_DATA;
                ST_STATUS: nxt = ST_STATUS;
                ST_IGNORE: nxt = ST_IGNORE;
                default:   nxt = ST_IGNORE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign commit  = cs_rise && (state == ST_DATA) && on_boundary && data_seen;
    assign wren_ok = cs_rise && (state == ST_WREN) && on_boundary && !busy;
    assign tx_load = byte_valid &&
                     (((state == ST_IDLE) && (rx_byte == OP_RDSR)) || (state == ST_STATUS));
    assign tx_byte = {6'b0, wel, busy};
    assign buf_byte = pbuf[rd_idx];
    assign buf_hit  = pmask[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel       <= 1'b0;
            addr_cnt  <= '0;
            addr_hi   <= '0;
            wr_off    <= '0;
            data_seen <= 1'b0;
            pmask     <= '0;
            prog_page <= '0;
        end else begin
            if (prog_done)
                wel <= 1'b0;
            else if (wren_ok)
                wel <= 1'b1;
            if (byte_valid) begin
                if (state == ST_IDLE && nxt == ST_ADDR) begin
                    addr_cnt  <= '0;
                    data_seen <= 1'b0;
                    pmask     <= '0;
                end else if (state == ST_ADDR) begin
                    addr_cnt <= addr_cnt + 2'd1;
                    if (addr_cnt == 2'd2) begin
                        wr_off    <= rx_byte;
                        prog_page <= PGW'({addr_hi, rx_byte} >> PAGE_BITS);
                    end else
                        addr_hi <= {addr_hi[7:0], rx_byte};
                end else if (state == ST_DATA) begin
                    pmask[wr_off] <= 1'b1;
                    wr_off        <= wr_off + 1'b1;
                    data_seen     <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (byte_valid && state == ST_DATA)
            pbuf[wr_off] <= rx_byte;
    end
endmodule

// File: rtl/nor_prog_engine.sv
module nor_prog_engine
    import nor_prog_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int TPP_CYCLES = 4096
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [ADDR_W-PAGE_BITS-1:0] page_in,
    input  logic [7:0]                  buf_byte,
    input  logic                        buf_hit,
    input  logic [7:0]                  cell_q,
    output logic                        busy,
    output logic                        done,
    output logic [PAGE_BITS-1:0]        idx,
    output logic                        we,
    output logic [ADDR_W-1:0]           waddr,
    output logic [7:0]                  wdata
);
    localparam int CNT_W = $clog2(TPP_CYCLES + 1);

    logic [CNT_W-1:0]            cnt;
    logic [ADDR_W-PAGE_BITS-1:0] page;

    assign done  = busy && (cnt == CNT_W'(TPP_CYCLES - 1));
    assign idx   = cnt[PAGE_BITS-1:0];
    assign we    = busy && (cnt < CNT_W'(PAGE_BYTES)) && buf_hit;
    assign waddr = {page, idx};
    assign wdata = cell_q & buf_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            page <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
            page <= page_in;
        end else if (busy) begin
            if (done) busy <= 1'b0;
            else      cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    output logic [7:0]        wq,
    input  logic [ADDR_W-1:0] bd_addr,
    output logic [7:0]        bd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    assign wq      = cells[waddr];
    assign bd_data = cells[bd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/nor_prog_target.sv
module nor_prog_target
    import nor_prog_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int TPP_CYCLES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [ADDR_W-1:0] bd_addr,
    output logic [7:0]        bd_data
);
    localparam int PGW = ADDR_W - PAGE_BITS;

    logic                 byte_valid, on_boundary, cs_rise, tx_load;
    logic [7:0]           rx_byte, tx_byte;
    logic                 busy, wel, commit, prog_done, buf_hit, arr_we;
    logic [PGW-1:0]       prog_page;
    logic [PAGE_BITS-1:0] eng_idx;
    logic [7:0]           buf_byte, cell_q, arr_wdata;
    logic [ADDR_W-1:0]    arr_waddr;

    nor_spi_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
        .tx_load(tx_load), .tx_byte(tx_byte), .miso(spi_miso),
        .byte_valid(byte_valid), .rx_byte(rx_byte),
        .on_boundary(on_boundary), .cs_rise(cs_rise)
    );

    nor_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .rx_byte(rx_byte),
        .cs_rise(cs_rise), .on_boundary(on_boundary), .busy(busy),
        .prog_done(prog_done), .rd_idx(eng_idx), .tx_load(tx_load),
        .tx_byte(tx_byte), .wel(wel), .commit(commit), .prog_page(prog_page),
        .buf_byte(buf_byte), .buf_hit(buf_hit)
    );

    nor_prog_engine #(.ADDR_W(ADDR_W), .TPP_CYCLES(TPP_CYCLES)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(commit), .page_in(prog_page),
        .buf_byte(buf_byte), .buf_hit(buf_hit), .cell_q(cell_q),
        .busy(busy), .done(prog_done), .idx(eng_idx), .we(arr_we),
        .waddr(arr_waddr), .wdata(arr_wdata)
    );

    nor_cell_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_waddr),
        .wdata(arr_wdata), .wq(cell_q), .bd_addr(bd_addr), .bd_data(bd_data)
    );
endmodule

// File: rtl/nor_prog_target_chk.sv
module nor_prog_target_chk #(
    parameter int TPP = 4096
) (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_miso,
    input logic busy,
    input logic wel,
    input logic commit,
    input logic arr_we
);
    int unsigned bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bcnt <= 0;
        else        bcnt <= busy ? bcnt + 1 : 0;
    end

    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_miso); // R11
    AST_COMMIT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> wel); // R6
    AST_NO_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !commit); // R8
    AST_COMMIT_ON_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> spi_cs_n); // R5
    AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy); // R7
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt < TPP)); // R7
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == TPP)); // R7
    AST_WEL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel); // R7
    AST_WRITE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy); // R4
endmodule

bind nor_prog_target nor_prog_target_chk #(.TPP(TPP_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
    .busy(busy), .wel(wel), .commit(commit), .arr_we(arr_we)
);

// File: tb/nor_prog_target_tb_top.sv
`timescale 1ns/1ps
module nor_prog_target_tb_top;
    localparam int AW    = 9;
    localparam int TPP   = 600;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic          miso;
    logic [AW-1:0] bd_addr = '0;
    logic [7:0]    bd_data;

    int n_chk = 0, n_fail = 0, cyc = 0, t_rise = 0;
    bit finished = 0;
    logic [7:0] model [DEPTH];
    logic [7:0] dbuf [512];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nor_prog_target #(.ADDR_W(AW), .TPP_CYCLES(TPP)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso), .bd_addr(bd_addr), .bd_data(bd_data)
    );

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic check_array(input string req);
        int bad = -1;
        logic [7:0] got = 8'h00;
        n_chk++;
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            bd_addr = AW'(a);
            #1;
            if (bd_data !== model[a] && bad < 0) begin
                bad = a;
                got = bd_data;
            end
        end
        if (bad >= 0) begin
            n_fail++;
            $display("FAIL %s addr=%0h actual=%02h expected=%02h", req, bad, got, model[bad]);
        end
    endtask

    task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            @(negedge clk); mosi = tx[i];
            @(negedge clk); rx[i] = miso; sck = 1'b1;
            @(negedge clk);
            @(negedge clk); sck = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic cs_lo();
        @(negedge clk); cs_n = 1'b0;
    endtask

    task automatic cs_hi();
        @(negedge clk); cs_n = 1'b1; t_rise = cyc;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd_status(output logic [7:0] s);
        logic [7:0] d;
        cs_lo(); xbyte(8'h05, d); xbyte(8'h00, s); cs_hi();
    endtask

    task automatic wren();
        logic [7:0] d;
        cs_lo(); xbyte(8'h06, d); cs_hi();
    endtask

    task automatic send_prog(input logic [23:0] a, input int n);
        logic [7:0] d;
        cs_lo();
        xbyte(8'h02, d); xbyte(a[23:16], d); xbyte(a[15:8], d); xbyte(a[7:0], d);
        for (int i = 0; i < n; i++) xbyte(dbuf[i], d);
        cs_hi();
    endtask

    task automatic model_prog(input logic [23:0] a, input int n);
        logic [7:0] pb [256];
        logic       pm [256];
        logic [7:0] off = a[7:0];
        for (int j = 0; j < 256; j++) pm[j] = 1'b0;
        for (int i = 0; i < n; i++) begin
            pb[off] = dbuf[i]; pm[off] = 1'b1; off = off + 8'd1;
        end
        for (int j = 0; j < 256; j++)
            if (pm[j]) model[{a[AW-1:8], 8'(j)}] &= pb[j];
    endtask

    task automatic wait_idle(output logic [7:0] first, output logic [7:0] last);
        logic [7:0] d;
        cs_lo(); xbyte(8'h05, d);
        xbyte(8'h00, first); last = first;
        for (int k = 0; k < 40 && last[0]; k++) xbyte(8'h00, last);
        cs_hi();
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R7 watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, f, l, d;
        int t0;
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state, R11 idle output
        chk8("R11 miso idle", {7'b0, miso}, 8'h00);
        rd_status(s); chk8("R1 status after reset", s, 8'h00);
        check_array("R1 erased array");

        // R6 program without latch
        for (int i = 0; i < 4; i++) dbuf[i] = 8'h00;
        send_prog(24'h000020, 4);
        rd_status(s); chk8("R6 no busy without WEL", s, 8'h00);
        check_array("R6 array untouched");

        // R3 latch set
        wren(); rd_status(s); chk8("R3 WEL set", s, 8'h02);

        // R4 R7 R8 R2: program, then traffic while busy
        for (int i = 0; i < 8; i++) dbuf[i] = 8'(8'h30 + i);
        send_prog(24'h000010, 8);
        t0 = t_rise;
        model_prog(24'h000010, 8);
        rd_status(s); chk8("R2 status while busy", s, 8'h03);
        for (int i = 0; i < 2; i++) dbuf[i] = 8'h00;
        send_prog(24'h000140, 2);          // R8 dropped while busy
        wren();                            // R3 ignored while busy
        wait_until(t0 + TPP - 90);
        rd_status(s); chk8("R7 busy near end of window", s, 8'h03);
        wait_until(t0 + TPP + 5);
        rd_status(s); chk8("R7 WEL cleared, R3 late WREN ignored", s, 8'h00);
        check_array("R8 busy program dropped, R4 data placed");

        // R9 AND merge, R2 status refresh within one frame
        wren();
        for (int i = 0; i < 6; i++) dbuf[i] = 8'h0F ^ 8'(i << 5);
        send_prog(24'h000012, 6);
        model_prog(24'h000012, 6);
        wait_idle(f, l);
        chk8("R2 first poll busy", f, 8'h03);
        chk8("R2 last poll idle", l, 8'h00);
        check_array("R9 bits only cleared");

        // R10 wrap inside page, upper address bits dropped
        wren();
        for (int i = 0; i < 40; i++) dbuf[i] = 8'(i * 7 + 3);
        send_prog(24'hFE01F0, 40);
        model_prog(24'hFE01F0, 40);
        wait_idle(f, l);
        check_array("R10 wrap within page");

        // R10 last write wins on overlap
        wren();
        for (int i = 0; i < 300; i++) dbuf[i] = 8'(i) ^ 8'hA5;
        send_prog(24'h000080, 300);
        model_prog(24'h000080, 300);
        wait_idle(f, l);
        check_array("R10 overlap last byte used");

        // R5 truncated frames
        wren();
        cs_lo();
        xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h01, d); xbyte(8'h40, d);
        xbyte(8'h00, d); xbits(8'h00, 3, d);
        cs_hi();
        rd_status(s); chk8("R5 mid-byte rise no commit", s, 8'h02);
        cs_lo();
        xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h01, d); xbyte(8'h40, d);
        cs_hi();
        rd_status(s); chk8("R5 address-only frame", s, 8'h02);
        check_array("R5 array untouched");

        // R11 unknown opcode; R3 latch frame with extra byte
        cs_lo(); xbyte(8'h9F, d); xbyte(8'h00, d); xbyte(8'h00, d); cs_hi();
        rd_status(s); chk8("R11 unknown opcode ignored", s, 8'h02);
        dbuf[0] = 8'h00; dbuf[1] = 8'h00;
        send_prog(24'h000100, 2);
        model_prog(24'h000100, 2);
        wait_idle(f, l);
        chk8("R7 done and WEL clear", l, 8'h00);
        cs_lo(); xbyte(8'h06, d); xbyte(8'h00, d); cs_hi();
        rd_status(s); chk8("R3 extra byte blocks WEL", s, 8'h00);
        cs_lo(); xbits(8'h06, 6, d); cs_hi();
        rd_status(s); chk8("R3 partial WREN blocked", s, 8'h00);
        check_array("R4 program after refused frames");

        // R4 R9 single-byte sweep across page 1
        for (int k = 0; k < 16; k++) begin
            wren();
            dbuf[0] = ~(8'h01 << (k % 8));
            send_prog(24'h000100 + 24'(k * 17), 1);
            model_prog(24'h000100 + 24'(k * 17), 1);
            wait_idle(f, l);
            chk8("R7 sweep returns idle", l, 8'h00);
        end
        check_array("R4 single-byte sweep");
        chk8("R11 miso idle at end", {7'b0, miso}, 8'h00);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule